// File: doc/BRIEF.md
# Non-destructive AND-compare execute unit

This unit takes one decoded instruction of the AND-compare family and turns it into new status flags. The fields arrive together on an input handshake: the opcode byte, the reg field of the ModRM byte, three prefix indications (64-bit operand promotion, operand-size override, bus lock), a mode bit that says whether the core runs in 64-bit mode, a 32-bit immediate field and two operand values that were already fetched. The operand on `op_rm` is the r/m operand, or the accumulator for the accumulator forms. The operand on `op_reg` is the register named by the reg field.

The unit claims six opcodes. It picks an operand width of 8, 16, 32 or 64 bits and forms the immediate, sign-extending it in 64-bit operation. It ANDs the two sources and throws the AND value away. It then produces sign, zero and parity flags. Carry, overflow and auxiliary carry are driven to zero. A bus-lock prefix on a claimed opcode raises an invalid-opcode fault. An opcode outside the family is reported on a separate output, with no fault. In both of these cases the flag outputs keep their old values.

The result sits in one output register with a valid/ready pair. `in_ready` is high when the register is empty or is being drained in the same cycle: `in_ready = !out_valid || out_ready`. An instruction is accepted on a rising edge where `in_valid && in_ready`, and its result is visible after that edge. While `out_valid` is high and `out_ready` is low, the register and every output hold. With `out_ready` held high, each accepted instruction gives exactly one cycle of `out_valid`.

Top module: `andcmp_unit`

## Requirements
- R1: While reset is asserted and right after it, `out_valid`, `fault_ud`, `not_ours` and all six flag outputs are 0, and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An accepted instruction sets `out_valid` in the next cycle. A stalled result (valid and not ready) holds every output. `out_valid` falls after a cycle where it was consumed and nothing was accepted.
- R3: Opcodes 84h, F6h and A8h work on 8 bits. Opcodes 85h, F7h and A9h work on 64 bits when `mode64` and `pfx_w` are both set, on 16 bits when `pfx_opsz` is set otherwise, and on 32 bits in all other cases. `pfx_w` has no effect when `mode64` is 0.
- R4: Opcodes 84h and 85h AND `op_rm` with `op_reg`. Opcodes F6h, F7h, A8h and A9h AND `op_rm` with the immediate. The immediate is the low 8, 16 or 32 bits of `imm`, zero-extended, and in 64-bit operation it is `imm` sign-extended from bit 31.
- R5: `flag_sf` is the most significant bit of the AND value at the active width.
- R6: `flag_zf` is 1 exactly when the AND value is zero across the active width. Bits above that width do not matter.
- R7: `flag_pf` is 1 when bits 7..0 of the AND value hold an even number of ones, for every width.
- R8: `flag_cf`, `flag_of` and `flag_af` are 0 after every claimed instruction.
- R9: A claimed opcode with `pfx_lock` set gives `fault_ud` = 1 and `not_ours` = 0, and all six flag outputs keep their previous values.
- R10: Any opcode other than the six above, and F6h or F7h with a nonzero `modrm_reg`, gives `not_ours` = 1 and `fault_ud` = 0, even when `pfx_lock` is set, and all flag outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction fields are present |
| in_ready | output | 1 | Unit can accept an instruction this cycle |
| opcode | input | 8 | Primary opcode byte |
| modrm_reg | input | 3 | Reg field (bits 5..3) of the ModRM byte |
| pfx_w | input | 1 | 64-bit operand promotion prefix bit |
| pfx_opsz | input | 1 | Operand-size override prefix present |
| pfx_lock | input | 1 | Bus-lock prefix present |
| mode64 | input | 1 | Core runs in 64-bit mode |
| imm | input | 32 | Immediate field, right-aligned |
| op_rm | input | 64 | r/m operand value, or the accumulator |
| op_reg | input | 64 | Value of the register named by the reg field |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| fault_ud | output | 1 | Invalid-opcode fault |
| not_ours | output | 1 | Opcode does not belong to this family |
| flag_sf | output | 1 | Sign flag |
| flag_zf | output | 1 | Zero flag |
| flag_pf | output | 1 | Parity flag |
| flag_cf | output | 1 | Carry flag |
| flag_of | output | 1 | Overflow flag |
| flag_af | output | 1 | Auxiliary-carry flag |

## Verification
All internal state lives in the one output register, so any wrong state shows at the ports one cycle after the instruction that caused it. Width or immediate errors show up as wrong sign or zero flags only when the operands are chosen to tell the widths apart: bits above the active width set, the top bit of the immediate set, or the top bit of the operand set. A classification error shows as `fault_ud` or `not_ours` rising for the wrong opcode. It also shows as flags that change when they should hold, and this is seen on the very next valid result. A handshake fault shows within one cycle of a stall or a drain, as a result that is duplicated or lost.

// File: rtl/andcmp_pkg.sv
package andcmp_pkg;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2,
    WID_64 = 2'd3
  } width_e;

  typedef struct packed {
    logic   claim;
    logic   use_imm;
    width_e width;
  } dec_s;

  // Opcodes with the low bit cleared; the low bit selects byte (0) or wider (1)
  localparam logic [6:0] FAM_REGREG = 7'h42;
  localparam logic [6:0] FAM_GROUP  = 7'h7B;
  localparam logic [6:0] FAM_ACCUM  = 7'h54;

endpackage

// File: rtl/andcmp_decode.sv
module andcmp_decode
  import andcmp_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [2:0] modrm_reg,
  input  logic       pfx_w,
  input  logic       pfx_opsz,
  input  logic       mode64,
  output dec_s       dec
);

  logic is_regreg, is_group, is_accum, is_byte;

  always_comb begin
    is_regreg = (opcode[7:1] == FAM_REGREG);
    is_group  = (opcode[7:1] == FAM_GROUP) && (modrm_reg == 3'd0);
    is_accum  = (opcode[7:1] == FAM_ACCUM);
    is_byte   = !opcode[0];

    dec.claim   = is_regreg || is_group || is_accum;
    dec.use_imm = is_group || is_accum;

    if (is_byte)             dec.width = WID_8;
    else if (mode64 && pfx_w) dec.width = WID_64;
    else if (pfx_opsz)       dec.width = WID_16;
    else                     dec.width = WID_32;
  end

endmodule

// File: rtl/andcmp_imm.sv
module andcmp_imm
  import andcmp_pkg::*;
#(
  parameter int DW = 64,
  parameter int IW = 32
) (
  input  width_e          width,
  input  logic [IW-1:0]   imm,
  output logic [DW-1:0]   imm_ext
);

  localparam int EXTW = DW - IW;

  always_comb begin
    unique case (width)
      WID_8:   imm_ext = DW'(imm[7:0]);
      WID_16:  imm_ext = DW'(imm[15:0]);
      WID_32:  imm_ext = DW'(imm);
      default: imm_ext = {{EXTW{imm[IW-1]}}, imm};
    endcase
  end

endmodule

// File: rtl/andcmp_flags.sv
module andcmp_flags
  import andcmp_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  width_e        width,
  output logic          sf,
  output logic          zf,
  output logic          pf
);

  localparam int NLANE = $clog2(DW / 8) + 1;

  logic [DW-1:0]    conj;
  logic [NLANE-1:0] lane_msb;
  logic [NLANE-1:0] lane_zero;

  assign conj = src_a & src_b;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = 8 << g;
    assign lane_msb[g]  = conj[LW-1];
    assign lane_zero[g] = ~|conj[LW-1:0];
  end

  assign sf = lane_msb[width];
  assign zf = lane_zero[width];
  assign pf = ~^conj[7:0];

endmodule

// File: rtl/andcmp_unit.sv
module andcmp_unit
  import andcmp_pkg::*;
#(
  parameter int DW = 64,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    opcode,
  input  logic [2:0]    modrm_reg,
  input  logic          pfx_w,
  input  logic          pfx_opsz,
  input  logic          pfx_lock,
  input  logic          mode64,
  input  logic [IW-1:0] imm,
  input  logic [DW-1:0] op_rm,
  input  logic [DW-1:0] op_reg,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          fault_ud,
  output logic          not_ours,
  output logic          flag_sf,
  output logic          flag_zf,
  output logic          flag_pf,
  output logic          flag_cf,
  output logic          flag_of,
  output logic          flag_af
);

  dec_s          dec;
  logic [DW-1:0] imm_ext;
  logic [DW-1:0] src_b;
  logic          nxt_sf, nxt_zf, nxt_pf;
  logic          accept;
  logic          do_update;

  andcmp_decode u_decode (
    .opcode    (opcode),
    .modrm_reg (modrm_reg),
    .pfx_w     (pfx_w),
    .pfx_opsz  (pfx_opsz),
    .mode64    (mode64),
    .dec       (dec)
  );

  andcmp_imm #(.DW(DW), .IW(IW)) u_imm (
    .width   (dec.width),
    .imm     (imm),
    .imm_ext (imm_ext)
  );

  assign src_b = dec.use_imm ? imm_ext : op_reg;

  andcmp_flags #(.DW(DW)) u_flags (
    .src_a (op_rm),
    .src_b (src_b),
    .width (dec.width),
    .sf    (nxt_sf),
    .zf    (nxt_zf),
    .pf    (nxt_pf)
  );

  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign do_update = accept && dec.claim && !pfx_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      fault_ud  <= 1'b0;
      not_ours  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      fault_ud  <= dec.claim && pfx_lock;
      not_ours  <= !dec.claim;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_sf <= 1'b0;
      flag_zf <= 1'b0;
      flag_pf <= 1'b0;
      flag_cf <= 1'b0;
      flag_of <= 1'b0;
      flag_af <= 1'b0;
    end else if (do_update) begin
      flag_sf <= nxt_sf;
      flag_zf <= nxt_zf;
      flag_pf <= nxt_pf;
      flag_cf <= 1'b0;
      flag_of <= 1'b0;
      flag_af <= 1'b0;
    end
  end

endmodule

// File: rtl/andcmp_chk.sv
module andcmp_chk #(
  parameter int DW = 64,
  parameter int IW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [7:0]    opcode,
  input logic [2:0]    modrm_reg,
  input logic          pfx_w,
  input logic          pfx_lock,
  input logic          mode64,
  input logic [IW-1:0] imm,
  input logic [DW-1:0] op_rm,
  input logic          out_valid,
  input logic          out_ready,
  input logic          fault_ud,
  input logic          not_ours,
  input logic          flag_sf,
  input logic          flag_zf,
  input logic          flag_pf,
  input logic          flag_cf,
  input logic          flag_of,
  input logic          flag_af
);

  logic [5:0] flags;
  assign flags = {flag_sf, flag_zf, flag_pf, flag_cf, flag_of, flag_af};

  assert_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(flags) && $stable(fault_ud) && $stable(not_ours)));

  assert_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && opcode == 8'hF7 && modrm_reg == 3'd0 && mode64 && pfx_w
     && !pfx_lock && imm[IW-1] && op_rm[DW-1]) |=> flag_sf);

  assert_zf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && opcode == 8'hA8 && !pfx_lock)
    |=> (flag_zf == ($past(op_rm[7:0] & imm[7:0]) == 8'd0)));

  assert_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && opcode == 8'hA8 && pfx_lock) |=> (fault_ud && !not_ours));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (fault_ud || not_ours)) |-> $stable(flags));

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(fault_ud && not_ours));

endmodule

bind andcmp_unit andcmp_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .opcode    (opcode),
  .modrm_reg (modrm_reg),
  .pfx_w     (pfx_w),
  .pfx_lock  (pfx_lock),
  .mode64    (mode64),
  .imm       (imm),
  .op_rm     (op_rm),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .fault_ud  (fault_ud),
  .not_ours  (not_ours),
  .flag_sf   (flag_sf),
  .flag_zf   (flag_zf),
  .flag_pf   (flag_pf),
  .flag_cf   (flag_cf),
  .flag_of   (flag_of),
  .flag_af   (flag_af)
);

// File: tb/andcmp_unit_tb.sv
module andcmp_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  opcode = 8'h00;
  logic [2:0]  modrm_reg = 3'd0;
  logic        pfx_w = 1'b0, pfx_opsz = 1'b0, pfx_lock = 1'b0, mode64 = 1'b0;
  logic [31:0] imm = '0;
  logic [63:0] op_rm = '0, op_reg = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        fault_ud, not_ours;
  logic        flag_sf, flag_zf, flag_pf, flag_cf, flag_of, flag_af;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit rdy_rand = 0;
  bit done = 0;

  always #4 clk = ~clk;

  andcmp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opcode(opcode), .modrm_reg(modrm_reg), .pfx_w(pfx_w), .pfx_opsz(pfx_opsz),
    .pfx_lock(pfx_lock), .mode64(mode64), .imm(imm), .op_rm(op_rm), .op_reg(op_reg),
    .out_valid(out_valid), .out_ready(out_ready), .fault_ud(fault_ud), .not_ours(not_ours),
    .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_pf(flag_pf), .flag_cf(flag_cf),
    .flag_of(flag_of), .flag_af(flag_af)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference model
  bit m_v, m_fault, m_nm, m_sf, m_zf, m_pf;

  always @(posedge clk) begin
    bit acc, claim, rr;
    int w;
    logic [63:0] b, r, msk;
    if (!rst_n) begin
      m_v = 0; m_fault = 0; m_nm = 0; m_sf = 0; m_zf = 0; m_pf = 0;
    end else begin
      acc = in_valid && (!m_v || out_ready);
      if (acc) begin
        claim = 1; rr = 0; w = 32;
        case (opcode)
          8'h84: begin rr = 1; w = 8; end
          8'h85: rr = 1;
          8'hF6: begin claim = (modrm_reg == 0); w = 8; end
          8'hF7: claim = (modrm_reg == 0);
          8'hA8: w = 8;
          8'hA9: ;
          default: claim = 0;
        endcase
        if (w != 8) begin
          if (mode64 && pfx_w) w = 64;
          else if (pfx_opsz) w = 16;
        end
        msk = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        if (rr) b = op_reg;
        else if (w == 64) b = {{32{imm[31]}}, imm};
        else b = {32'd0, imm} & msk;
        r = op_rm & b & msk;
        m_v = 1;
        m_fault = claim && pfx_lock;
        m_nm = !claim;
        if (claim && !pfx_lock) begin
          m_sf = r[w-1];
          m_zf = (r == 0);
          m_pf = ~^r[7:0];
        end
      end else if (out_ready) begin
        m_v = 0;
      end
    end
    #2;
    if (rst_n && !done) begin
      chk("R2 out_valid", out_valid, m_v);
      chk("R2 in_ready", in_ready, !m_v || out_ready);
      if (m_v) begin
        chk("R9 fault_ud", fault_ud, m_fault);
        chk("R10 not_ours", not_ours, m_nm);
      end
      chk("R5 flag_sf", flag_sf, m_sf);
      chk("R6 flag_zf", flag_zf, m_zf);
      chk("R7 flag_pf", flag_pf, m_pf);
      chk("R8 flag_cf", flag_cf, 1'b0);
      chk("R8 flag_of", flag_of, 1'b0);
      chk("R8 flag_af", flag_af, 1'b0);
    end
  end

  always @(posedge clk) begin
    #3;
    out_ready <= rdy_rand ? (($urandom % 4) != 0) : 1'b1;
  end

  task automatic send(input logic [7:0] opc, input logic [2:0] rg, input bit w,
                      input bit osz, input bit lk, input bit m64, input logic [31:0] iv,
                      input logic [63:0] rm, input logic [63:0] rv);
    opcode = opc; modrm_reg = rg; pfx_w = w; pfx_opsz = osz; pfx_lock = lk;
    mode64 = m64; imm = iv; op_rm = rm; op_reg = rv; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [7:0] pick_op(input int k);
    case (k % 8)
      0: return 8'h84; 1: return 8'h85; 2: return 8'hF6; 3: return 8'hF7;
      4: return 8'hA8; 5: return 8'hA9; 6: return 8'h90;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", out_valid, 1'b0);
    chk("R1 in_ready", in_ready, 1'b1);
    chk("R1 fault_ud", fault_ud, 1'b0);
    chk("R1 not_ours", not_ours, 1'b0);
    chk("R1 flags", |{flag_sf, flag_zf, flag_pf, flag_cf, flag_of, flag_af}, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 R7: byte accumulator form, disjoint bits
    send(8'hA8, 3'd0, 0, 0, 0, 0, 32'h0000_00F0, 64'h0F, 64'h0);
    // R4 R5: 64-bit sign-extended immediate reaches bit 63
    send(8'hF7, 3'd0, 1, 0, 0, 1, 32'h8000_0000, 64'h8000_0000_0000_0000, 64'h0);
    // R3: promotion bit ignored outside 64-bit mode -> 32-bit, upper half discarded
    send(8'h85, 3'd5, 1, 0, 0, 0, 32'h0, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    // R3 R5: 16-bit width via size override
    send(8'hA9, 3'd0, 0, 1, 0, 0, 32'h0001_8000, 64'h0000_0000_0000_8000, 64'h0);
    // R7: parity of low byte only on 32-bit
    send(8'h85, 3'd1, 0, 0, 0, 1, 32'h0, 64'h0000_0000_0100_0003, 64'hFFFF_FFFF_FFFF_FFFF);
    // R9: lock fault holds flags
    send(8'hF6, 3'd0, 0, 0, 1, 1, 32'h0, 64'h0, 64'h0);
    // R10: group opcode with nonzero reg field, and an unrelated opcode with lock
    send(8'hF7, 3'd2, 0, 0, 0, 1, 32'h0, 64'h0, 64'h0);
    send(8'h90, 3'd0, 0, 0, 1, 1, 32'h0, 64'h0, 64'h0);
    send(8'h84, 3'd0, 0, 0, 0, 1, 32'h0, 64'h80, 64'hFF);
    // R2: random back-pressure and mixed traffic
    rdy_rand = 1;
    for (int i = 0; i < 400; i++) begin
      send(pick_op($urandom), (($urandom % 4) == 0) ? 3'($urandom) : 3'd0,
           1'($urandom), 1'($urandom), (($urandom % 8) == 0), 1'($urandom),
           $urandom, {$urandom, $urandom}, {$urandom, $urandom});
      if (($urandom % 5) == 0) @(negedge clk);
    end
    rdy_rand = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule